// File: doc/BRIEF.md
# Two-Stage Synchronizer with Metastability Injection

This block carries an N-bit signal from a foreign clock domain into a receive clock domain through a chain of two registers. It also has a simulation aid. When injection is turned on, an outside flag can mark the current receive edge as lying very close to a transmit edge. In that case, any input bit that is in the middle of a change may have its sampled value inverted before it enters the first register. The choice to invert is pseudo-random and is made separately for each bit. An inverted load keeps the old level for one more cycle. Relative to an ideal simulation aligned to the other edge, this shows up as a one-cycle delay or a one-cycle advance, so downstream logic sees the timing spread that real silicon can produce.

A second two-register chain runs next to the first with injection permanently off. Its output is exposed so that a consumer can compare the perturbed path with the ideal one. A per-bit strobe marks every cycle in which an inversion is sitting in the first register. The block does not measure clock phase. The edge-proximity flag comes from outside, and a single flag is shared by every bit that crosses between the same pair of domains.

Top module: `cdc_inject_sync`

## Requirements
- R1: While reset is asserted (rst_n low), sync_out, ref_out and inj_strobe are all zero.
- R2: With inj_enable low, sync_out equals async_in as sampled two rising edges earlier, bit for bit, whatever the other inputs do.
- R3: With edge_near low, no bit is ever inverted, and inj_strobe stays zero even when inj_enable is high.
- R4: At a rising edge, bit i of the first stage is loaded with the complement of async_in[i] only when all of these hold: inj_enable is high, edge_near is high, async_in[i] differs from the current first-stage bit i, and decision bit i is 1. Otherwise the first stage loads async_in[i]. An inverted bit therefore keeps its old level, and sync_out lags ref_out by one cycle for that change.
- R5: inj_strobe[i] is high for exactly the cycle after an edge that inverted bit i, and is low otherwise.
- R6: Each bit decides on its own. Decision bit i is bit i of the pseudo-random state at that edge (WIDTH at most 16), so different bits can be inverted or passed at the same edge.
- R7: The pseudo-random state is 16 bits. Reset loads it from seed. It advances at every rising edge out of reset as next = (s >> 1) XOR (s[0] ? 16'hB400 : 0), and it is never zero.
- R8: A seed of zero is replaced by 16'hACE1.
- R9: ref_out always equals async_in from two rising edges earlier, unaffected by injection.
- R10: A bit whose input equals its first-stage value is never inverted, even with inj_enable and edge_near both high, so a steady input passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rx | input | 1 | Receive-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| async_in | input | WIDTH | Data arriving from the other clock domain |
| inj_enable | input | 1 | Turns metastability injection on |
| edge_near | input | 1 | Marks the current receive edge as close to a transmit edge |
| seed | input | 16 | Pseudo-random state loaded during reset |
| sync_out | output | WIDTH | Synchronized data, including any injected effect |
| ref_out | output | WIDTH | Synchronized data from the injection-free chain |
| inj_strobe | output | WIDTH | Per-bit marker of an inversion held in the first stage |

## Verification
The assertions check several properties on every cycle. They confirm that the first stage equals the prior input except on exactly the strobed bits. They confirm that strobes appear only after edges where both injection gates were high, and that no strobe appears otherwise. They also confirm that the reference chain is a pure two-edge delay and that the pseudo-random state never becomes zero. Only the bench's scenarios can show the exact per-bit decisions. These include which bits flip under a given seed, the substitution for a zero seed, the one-cycle lag of sync_out behind ref_out on an inverted change, and steady inputs passing untouched while the proximity flag is held high.

// File: rtl/cdc_sync_pkg.sv
package cdc_sync_pkg;

    localparam int          RNG_W      = 16;
    localparam logic [15:0] RNG_TAPS   = 16'hB400;
    localparam logic [15:0] RNG_SUBST  = 16'hACE1;

    typedef logic [RNG_W-1:0] rng_t;

    function automatic rng_t rng_step(input rng_t s);
        return (s >> 1) ^ (s[0] ? RNG_TAPS : '0);
    endfunction

    function automatic rng_t rng_init(input rng_t s);
        return (s == '0) ? RNG_SUBST : s;
    endfunction

endpackage

// File: rtl/cdc_rng.sv
module cdc_rng
    import cdc_sync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  rng_t seed,
    output rng_t state
);
    typedef struct packed {
        rng_t val;
    } rng_state_t;

    rng_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.val = rng_step(st_q.val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.val <= rng_init(seed);
        end else begin
            st_q <= st_d;
        end
    end

    assign state = st_q.val;
endmodule

// File: rtl/cdc_flip_gen.sv
module cdc_flip_gen #(
    parameter int WIDTH = 4
) (
    input  logic             enable,
    input  logic             near,
    input  logic [WIDTH-1:0] raw,
    input  logic [WIDTH-1:0] held,
    input  logic [WIDTH-1:0] coin,
    output logic [WIDTH-1:0] flip
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic moving;
        assign moving  = raw[i] ^ held[i];
        assign flip[i] = enable & near & moving & coin[i];
    end
endmodule

// File: rtl/cdc_two_stage.sv
module cdc_two_stage #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  logic [WIDTH-1:0] flip,
    output logic [WIDTH-1:0] stage1,
    output logic [WIDTH-1:0] stage2
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } pipe_t;

    pipe_t p_d, p_q;

    always_comb begin
        p_d    = p_q;
        p_d.s1 = din ^ flip;
        p_d.s2 = p_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign stage1 = p_q.s1;
    assign stage2 = p_q.s2;
endmodule

// File: rtl/cdc_inject_sync.sv
module cdc_inject_sync
    import cdc_sync_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk_rx,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    input  logic             inj_enable,
    input  logic             edge_near,
    input  logic [15:0]      seed,
    output logic [WIDTH-1:0] sync_out,
    output logic [WIDTH-1:0] ref_out,
    output logic [WIDTH-1:0] inj_strobe
);
    typedef struct packed {
        logic [WIDTH-1:0] strobe;
    } top_state_t;

    top_state_t t_d, t_q;

    rng_t             rng_w;
    logic [WIDTH-1:0] flip_w;
    logic [WIDTH-1:0] stage1_w;
    logic [WIDTH-1:0] ref1_w;

    cdc_rng u_rng (
        .clk   (clk_rx),
        .rst_n (rst_n),
        .seed  (seed),
        .state (rng_w)
    );

    cdc_flip_gen #(.WIDTH(WIDTH)) u_flip (
        .enable (inj_enable),
        .near   (edge_near),
        .raw    (async_in),
        .held   (stage1_w),
        .coin   (rng_w[WIDTH-1:0]),
        .flip   (flip_w)
    );

    cdc_two_stage #(.WIDTH(WIDTH)) u_main (
        .clk    (clk_rx),
        .rst_n  (rst_n),
        .din    (async_in),
        .flip   (flip_w),
        .stage1 (stage1_w),
        .stage2 (sync_out)
    );

    cdc_two_stage #(.WIDTH(WIDTH)) u_ref (
        .clk    (clk_rx),
        .rst_n  (rst_n),
        .din    (async_in),
        .flip   ('0),
        .stage1 (ref1_w),
        .stage2 (ref_out)
    );

    always_comb begin
        t_d        = t_q;
        t_d.strobe = flip_w;
    end

    always_ff @(posedge clk_rx or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign inj_strobe = t_q.strobe;
endmodule

// File: rtl/cdc_inject_sync_chk.sv
module cdc_inject_sync_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk_rx,
    input logic             rst_n,
    input logic [WIDTH-1:0] async_in,
    input logic             inj_enable,
    input logic             edge_near,
    input logic [WIDTH-1:0] sync_out,
    input logic [WIDTH-1:0] ref_out,
    input logic [WIDTH-1:0] inj_strobe,
    input logic [WIDTH-1:0] stage1,
    input logic [15:0]      rng_state,
    input logic [WIDTH-1:0] ref_stage1
);
    logic [1:0] since_rst;

    always_ff @(posedge clk_rx or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // R1
    a_r1_reset_clear: assert property (@(posedge clk_rx)
        !rst_n |-> (sync_out == '0 && ref_out == '0 && inj_strobe == '0));

    // R3
    a_r3_no_flip_when_idle: assert property (@(posedge clk_rx) disable iff (!rst_n)
        !(inj_enable && edge_near) |=> (inj_strobe == '0));

    // R4
    a_r4_stage1_follows_input: assert property (@(posedge clk_rx) disable iff (!rst_n)
        (since_rst != 2'd0) |-> (((stage1 ^ $past(async_in)) ^ inj_strobe) == '0));

    // R5
    a_r5_strobe_gated: assert property (@(posedge clk_rx) disable iff (!rst_n)
        (since_rst != 2'd0 && inj_strobe != '0) |-> $past(inj_enable && edge_near));

    // R10
    a_r10_steady_bits_pass: assert property (@(posedge clk_rx) disable iff (!rst_n)
        (since_rst != 2'd0) |-> ((inj_strobe & ~($past(async_in) ^ $past(stage1))) == '0));

    // R7
    a_r7_state_nonzero: assert property (@(posedge clk_rx) disable iff (!rst_n)
        rng_state != '0);

    // R9
    a_r9_ref_delay: assert property (@(posedge clk_rx) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (ref_out == $past(async_in, 2)));

    // R9 first stage of the reference chain
    a_r9_ref_stage1: assert property (@(posedge clk_rx) disable iff (!rst_n)
        (since_rst != 2'd0) |-> (ref_stage1 == $past(async_in)));
endmodule

bind cdc_inject_sync cdc_inject_sync_chk #(.WIDTH(WIDTH)) u_chk (
    .clk_rx     (clk_rx),
    .rst_n      (rst_n),
    .async_in   (async_in),
    .inj_enable (inj_enable),
    .edge_near  (edge_near),
    .sync_out   (sync_out),
    .ref_out    (ref_out),
    .inj_strobe (inj_strobe),
    .stage1     (stage1_w),
    .rng_state  (rng_w),
    .ref_stage1 (ref1_w)
);

// File: tb/cdc_inject_sync_tb_top.sv
module cdc_inject_sync_tb_top;
    localparam int W = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  async_in = '0;
    logic          inj_enable = 1'b0;
    logic          edge_near = 1'b0;
    logic [15:0]   seed = 16'h1234;
    logic [W-1:0]  sync_out, ref_out, inj_strobe;

    always #4 clk = ~clk;

    cdc_inject_sync #(.WIDTH(W)) dut_i (
        .clk_rx(clk), .rst_n(rst_n), .async_in(async_in),
        .inj_enable(inj_enable), .edge_near(edge_near), .seed(seed),
        .sync_out(sync_out), .ref_out(ref_out), .inj_strobe(inj_strobe)
    );

    typedef struct {
        logic [W-1:0] s;
        logic [W-1:0] r;
        logic [W-1:0] k;
        string        tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    logic [W-1:0] m_s1, m_s2, m_r1, m_r2;
    logic [15:0]  m_rng;
    int           flips_total;
    int           partial_edges;

    function automatic logic [15:0] next_rng(input logic [15:0] s);
        logic [15:0] t;
        t = {1'b0, s[15:1]};
        if (s[0]) t = t ^ 16'hB400;
        return t;
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_int(input string tag, input bit ok, input int act);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected condition", tag, act);
        end
    endtask

    task automatic do_reset(input logic [15:0] sd);
        @(negedge clk);
        rst_n = 1'b0; seed = sd; async_in = '0; inj_enable = 1'b0; edge_near = 1'b0;
        m_s1 = '0; m_s2 = '0; m_r1 = '0; m_r2 = '0;
        m_rng = (sd == 16'h0) ? 16'hACE1 : sd;
        @(negedge clk);
        @(negedge clk);
        chk("R1 sync", sync_out, '0);
        chk("R1 ref", ref_out, '0);
        chk("R1 strobe", inj_strobe, '0);
        rst_n = 1'b1;
    endtask

    // Driver: called at a falling edge, models the next rising edge, then waits.
    task automatic step(input logic [W-1:0] din, input logic en, input logic nr, input string tag);
        logic [W-1:0] fl;
        exp_t e;
        async_in = din; inj_enable = en; edge_near = nr;
        fl = (en && nr) ? ((din ^ m_s1) & m_rng[W-1:0]) : '0;
        if (fl != '0) flips_total++;
        if (fl != '0 && fl != (din ^ m_s1)) partial_edges++;
        m_s2 = m_s1; m_s1 = din ^ fl;
        m_r2 = m_r1; m_r1 = din;
        m_rng = next_rng(m_rng);
        e.s = m_s2; e.r = m_r2; e.k = fl; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk({e.tag, " sync_out"}, sync_out, e.s);
                chk("R9 ref_out", ref_out, e.r);
                chk("R5 inj_strobe", inj_strobe, e.k);
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int f0;
        flips_total = 0; partial_edges = 0;
        do_reset(16'h1234);
        // R2: injection disabled, proximity toggling
        for (int i = 0; i < 16; i++) step(W'(i * 7 + 3), 1'b0, i[0], "R2");
        // R3: enabled but edges not near
        for (int i = 0; i < 16; i++) step(W'(i * 5 ^ 9), 1'b1, 1'b0, "R3");
        chk_int("R3 no modeled flips", flips_total == 0, flips_total);
        // R4 / R6 / R7: injection active on changing data
        for (int i = 0; i < 40; i++) step(W'((i * 11) ^ (i >> 1)), 1'b1, 1'b1, "R4 R6 R7");
        chk_int("R4 flips occurred", flips_total > 0, flips_total);
        chk_int("R6 partial-bit edges", partial_edges > 0, partial_edges);
        // R10: steady input with both gates high
        step(4'hA, 1'b0, 1'b0, "R10");
        step(4'hA, 1'b0, 1'b0, "R10");
        f0 = flips_total;
        for (int i = 0; i < 8; i++) step(4'hA, 1'b1, 1'b1, "R10");
        chk_int("R10 no flips on steady data", flips_total == f0, flips_total - f0);
        chk("R10 steady value", sync_out, 4'hA);
        // R8: zero seed substitution
        step('0, 1'b0, 1'b0, "R8");
        step('0, 1'b0, 1'b0, "R8");
        do_reset(16'h0000);
        for (int i = 0; i < 40; i++) step(W'((i * 13) ^ 5), 1'b1, 1'b1, "R8 R7");
        step('0, 1'b0, 1'b0, "R2");
        step('0, 1'b0, 1'b0, "R2");
        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule